// File: doc/BRIEF.md
# Sized Add/Subtract Flag Generator

This block performs one addition or subtraction on two operands at a chosen operand size of 8, 16 or 32 bits. For that size it produces the sized result and six condition flags: carry, parity, auxiliary carry, zero, sign and overflow. The flags follow the conventions of a classic CISC integer unit. Carry and auxiliary carry report a borrow when the operation is a subtract. Parity is even parity taken over the low byte of the result.

An execution stage drives the operands, a carry or borrow input, the operation select and the size code. It reads the result and the flags back. The arithmetic is purely combinational. A parameter can add one register stage in front of the outputs, and that stage is present by default. With the stage present, reset puts the outputs into the state that describes a zero result. Operand bits above the selected size are ignored.

Top module: `arith_flag_unit`

## Requirements
- R1: For an add (sub_i = 0), res_o equals the low N bits of a + b + cin_i, where N is the selected size. Result bits at and above N are 0, and operand bits at and above N have no effect on any output.
- R2: For a subtract (sub_i = 1), cin_i acts as a borrow-in, and res_o equals the low N bits of a - b - cin_i.
- R3: cf_o is 1 when an add carries out of bit N-1. For a subtract it is 1 when a borrow into bit N-1 is needed, that is when a < b + cin_i unsigned.
- R4: af_o is 1 when an add carries out of bit 3. For a subtract it is 1 when a borrow into bit 3 is needed, that is when a[3:0] < b[3:0] + cin_i.
- R5: zf_o is 1 exactly when all N result bits are 0.
- R6: sf_o equals bit N-1 of the result.
- R7: of_o is 1 when the signed two's-complement result at N bits lies outside the range from -2^(N-1) to 2^(N-1)-1.
- R8: pf_o is 1 when res_o[7:0] holds an even number of ones, whatever the size.
- R9: The size code size_i selects N as follows: 2'b00 gives 8, 2'b01 gives 16, and both 2'b10 and 2'b11 give 32.
- R10: With the register stage (REG_OUT = 1), the outputs reflect the inputs present at the previous rising clock edge. While rst_n is low they hold res_o = 0, zf_o = 1, pf_o = 1 and the other flags at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| a_i | input | 32 | First operand (minuend for subtract) |
| b_i | input | 32 | Second operand (subtrahend for subtract) |
| cin_i | input | 1 | Carry-in for add, borrow-in for subtract |
| sub_i | input | 1 | 0 selects add, 1 selects subtract |
| size_i | input | 2 | Operand size code: 00 = 8, 01 = 16, 1x = 32 bits |
| res_o | output | 32 | Sized result, zero above the selected width |
| cf_o | output | 1 | Carry / borrow flag |
| pf_o | output | 1 | Even parity of res_o[7:0] |
| af_o | output | 1 | Carry or borrow at bit 3 |
| zf_o | output | 1 | Sized result is zero |
| sf_o | output | 1 | Top bit of sized result |
| of_o | output | 1 | Signed overflow at the selected width |

## Verification
With the default register stage, every result and every flag is due exactly one rising edge after the inputs are applied. There is no further pipelining, so all seven outputs change together. Each scenario task drives its inputs on a falling edge and waits for the next rising edge. It then samples all outputs on the following falling edge, half a period after they settled. A reference model in the bench computes the expected values from the operands and the size, using wide unsigned and signed integer arithmetic.

// File: rtl/afu_pkg.sv
package afu_pkg;

    localparam int DATA_W   = 32;
    localparam int N_LANES  = 3;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_WIDE  = 2'b11
    } size_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{cf: 1'b0, pf: 1'b1, af: 1'b0,
                                       zf: 1'b1, sf: 1'b0, of: 1'b0};

    function automatic int lane_width(input int lane, input int full_w);
        return full_w >> (N_LANES - 1 - lane);
    endfunction

endpackage

// File: rtl/afu_operand_prep.sv
module afu_operand_prep #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] b_eff_o,
    output logic              c_eff_o,
    output logic              af_o
);
    logic [4:0] nib_sum;

    // subtract runs as a + ~b + ~borrow
    always_comb begin
        b_eff_o = sub_i ? ~b_i : b_i;
        c_eff_o = cin_i ^ sub_i;
        nib_sum = {1'b0, a_i[3:0]} + {1'b0, b_eff_o[3:0]} + {4'b0, c_eff_o};
        af_o    = nib_sum[4] ^ sub_i;
    end
endmodule

// File: rtl/afu_lane.sv
module afu_lane #(
    parameter int LW = 8
) (
    input  logic [LW-1:0] a_i,
    input  logic [LW-1:0] b_eff_i,
    input  logic          c_eff_i,
    input  logic          sub_i,
    output logic [LW-1:0] sum_o,
    output logic          cf_o,
    output logic          of_o
);
    logic [LW:0] ext_sum;

    always_comb begin
        ext_sum = {1'b0, a_i} + {1'b0, b_eff_i} + {{LW{1'b0}}, c_eff_i};
        sum_o   = ext_sum[LW-1:0];
        cf_o    = ext_sum[LW] ^ sub_i;
        of_o    = (a_i[LW-1] == b_eff_i[LW-1]) && (sum_o[LW-1] != a_i[LW-1]);
    end
endmodule

// File: rtl/afu_flag_select.sv
module afu_flag_select
    import afu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int N_LANES = 3
) (
    input  logic [N_LANES-1:0][DATA_W-1:0] lane_sum_i,
    input  logic [N_LANES-1:0]             lane_cf_i,
    input  logic [N_LANES-1:0]             lane_of_i,
    input  logic [1:0]                     size_i,
    input  logic                           af_i,
    output logic [DATA_W-1:0]              res_o,
    output flags_t                         flags_o
);
    localparam int SEL_W = $clog2(N_LANES);

    logic [SEL_W-1:0] sel;
    logic [DATA_W-1:0] msb_mask;

    always_comb begin
        unique case (size_e'(size_i))
            SZ_BYTE:  sel = SEL_W'(0);
            SZ_WORD:  sel = SEL_W'(1);
            SZ_DWORD: sel = SEL_W'(2);
            SZ_WIDE:  sel = SEL_W'(2);
        endcase
        res_o    = lane_sum_i[sel];
        msb_mask = DATA_W'(1) << (lane_width(int'(sel), DATA_W) - 1);
        flags_o.cf = lane_cf_i[sel];
        flags_o.of = lane_of_i[sel];
        flags_o.af = af_i;
        flags_o.zf = (res_o == '0);
        flags_o.sf = |(res_o & msb_mask);
        flags_o.pf = ~^res_o[7:0];
    end
endmodule

// File: rtl/afu_out_stage.sv
module afu_out_stage
    import afu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] res_i,
    input  flags_t            flags_i,
    output logic [DATA_W-1:0] res_o,
    output flags_t            flags_o
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_o   <= '0;
                flags_o <= FLAGS_RESET;
            end else begin
                res_o   <= res_i;
                flags_o <= flags_i;
            end
        end
    end else begin : g_comb
        assign res_o   = res_i;
        assign flags_o = flags_i;
    end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
    import afu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       a_i,
    input  logic [31:0]       b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    input  logic [1:0]        size_i,
    output logic [31:0]       res_o,
    output logic              cf_o,
    output logic              pf_o,
    output logic              af_o,
    output logic              zf_o,
    output logic              sf_o,
    output logic              of_o
);
    localparam int LANES = afu_pkg::N_LANES;

    logic [DATA_W-1:0]             b_eff;
    logic                          c_eff;
    logic                          af_nib;
    logic [LANES-1:0][DATA_W-1:0]  lane_sum;
    logic [LANES-1:0]              lane_cf;
    logic [LANES-1:0]              lane_of;
    logic [DATA_W-1:0]             res_comb;
    flags_t                        flags_comb;
    flags_t                        flags_q;

    afu_operand_prep #(.DATA_W(DATA_W)) prep_i (
        .a_i     (a_i),
        .b_i     (b_i),
        .cin_i   (cin_i),
        .sub_i   (sub_i),
        .b_eff_o (b_eff),
        .c_eff_o (c_eff),
        .af_o    (af_nib)
    );

    for (genvar li = 0; li < LANES; li++) begin : g_lane
        localparam int LW = lane_width(li, DATA_W);
        logic [LW-1:0] sum_w;
        afu_lane #(.LW(LW)) lane_i (
            .a_i     (a_i[LW-1:0]),
            .b_eff_i (b_eff[LW-1:0]),
            .c_eff_i (c_eff),
            .sub_i   (sub_i),
            .sum_o   (sum_w),
            .cf_o    (lane_cf[li]),
            .of_o    (lane_of[li])
        );
        assign lane_sum[li] = DATA_W'(sum_w);
    end

    afu_flag_select #(.DATA_W(DATA_W), .N_LANES(LANES)) sel_i (
        .lane_sum_i (lane_sum),
        .lane_cf_i  (lane_cf),
        .lane_of_i  (lane_of),
        .size_i     (size_i),
        .af_i       (af_nib),
        .res_o      (res_comb),
        .flags_o    (flags_comb)
    );

    afu_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .res_i   (res_comb),
        .flags_i (flags_comb),
        .res_o   (res_o),
        .flags_o (flags_q)
    );

    assign cf_o = flags_q.cf;
    assign pf_o = flags_q.pf;
    assign af_o = flags_q.af;
    assign zf_o = flags_q.zf;
    assign sf_o = flags_q.sf;
    assign of_o = flags_q.of;
endmodule

// File: rtl/afu_checker.sv
module afu_checker #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] a_i,
    input logic [1:0]  size_i,
    input logic [31:0] res_o,
    input logic        pf_o,
    input logic        zf_o,
    input logic        sf_o,
    input logic        of_o
);
    logic [1:0]  sz_q;
    logic [31:0] a_q;
    logic [1:0]  sz_ref;
    logic [31:0] a_ref;
    logic [31:0] keep_mask;
    logic [31:0] top_mask;
    logic        seen;

    always_ff @(posedge clk) begin
        sz_q <= size_i;
        a_q  <= a_i;
        seen <= rst_n;
    end

    always_comb begin
        sz_ref = REG_OUT ? sz_q : size_i;
        a_ref  = REG_OUT ? a_q  : a_i;
        unique case (sz_ref)
            2'b00:   begin keep_mask = 32'h0000_00FF; top_mask = 32'h0000_0080; end
            2'b01:   begin keep_mask = 32'h0000_FFFF; top_mask = 32'h0000_8000; end
            default: begin keep_mask = 32'hFFFF_FFFF; top_mask = 32'h8000_0000; end
        endcase
    end

    // R1: nothing above the selected width
    a_r1_upper_clear: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (res_o & ~keep_mask) == 32'h0);

    // R5
    a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        zf_o == (res_o == 32'h0));

    // R6
    a_r6_sign_flag: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        sf_o == ((res_o & top_mask) != 32'h0));

    // R8
    a_r8_parity_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        pf_o == ~^res_o[7:0]);

    // R7: an overflowed result never keeps the sign of the first operand
    a_r7_overflow_sign: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        of_o |-> (sf_o != ((a_ref & top_mask) != 32'h0)));
endmodule

bind arith_flag_unit afu_checker #(.REG_OUT(REG_OUT)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_i    (a_i),
    .size_i (size_i),
    .res_o  (res_o),
    .pf_o   (pf_o),
    .zf_o   (zf_o),
    .sf_o   (sf_o),
    .of_o   (of_o)
);

// File: tb/arith_flag_unit_tb_top.sv
module arith_flag_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        cin_i = 1'b0;
    logic        sub_i = 1'b0;
    logic [1:0]  size_i = 2'b00;
    logic [31:0] res_o;
    logic        cf_o, pf_o, af_o, zf_o, sf_o, of_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    arith_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
        .sub_i(sub_i), .size_i(size_i), .res_o(res_o), .cf_o(cf_o),
        .pf_o(pf_o), .af_o(af_o), .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Independent model and comparison, one cycle after the drive
    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic c, input logic s, input logic [1:0] sz);
        int          n;
        longint      full, half, am, bm, sa, sb, sr;
        logic [31:0] e_res;
        logic        e_cf, e_af, e_of, e_zf, e_sf, e_pf;
        @(negedge clk);
        a_i = a; b_i = b; cin_i = c; sub_i = s; size_i = sz;
        n    = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;   // R9
        full = longint'(1) << n;
        half = full >> 1;
        am   = longint'(a) & (full - 1);
        bm   = longint'(b) & (full - 1);
        sa   = (am >= half) ? am - full : am;
        sb   = (bm >= half) ? bm - full : bm;
        if (!s) begin
            e_res = 32'((am + bm + c) & (full - 1));            // R1
            e_cf  = (am + bm + c) >= full;                       // R3
            e_af  = ((am & 15) + (bm & 15) + c) > 15;            // R4
            sr    = sa + sb + c;
        end else begin
            e_res = 32'((am - bm - c) & (full - 1));            // R2
            e_cf  = am < (bm + c);
            e_af  = (am & 15) < ((bm & 15) + c);
            sr    = sa - sb - c;
        end
        e_of = (sr < -half) || (sr > half - 1);                 // R7
        e_zf = (e_res == 0);
        e_sf = e_res[n-1];
        e_pf = ~^e_res[7:0];
        @(posedge clk);
        @(negedge clk);                                          // R10 latency
        chk(s ? "R2" : "R1", "res", res_o, e_res);
        chk("R3", "cf", 32'(cf_o), 32'(e_cf));
        chk("R4", "af", 32'(af_o), 32'(e_af));
        chk("R5", "zf", 32'(zf_o), 32'(e_zf));
        chk("R6", "sf", 32'(sf_o), 32'(e_sf));
        chk("R7", "of", 32'(of_o), 32'(e_of));
        chk("R8", "pf", 32'(pf_o), 32'(e_pf));
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R10", "reset res", res_o, 32'h0);
        chk("R10", "reset zf", 32'(zf_o), 32'd1);
        chk("R10", "reset pf", 32'(pf_o), 32'd1);
        chk("R10", "reset others", {26'b0, cf_o, af_o, sf_o, of_o, 2'b0}, 32'h0);
    endtask

    task automatic test_add_patterns();
        apply(32'h0000_0012, 32'h0000_0034, 1'b0, 1'b0, 2'b00);
        apply(32'h0000_00FF, 32'h0000_0001, 1'b0, 1'b0, 2'b00);
        apply(32'h0000_007F, 32'h0000_0000, 1'b1, 1'b0, 2'b00);
        apply(32'h0000_7FFF, 32'h0000_0001, 1'b0, 1'b0, 2'b01);
        apply(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 2'b10);
        apply(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 2'b10);
        apply(32'h1234_5678, 32'h0FED_CBA9, 1'b1, 1'b0, 2'b10);
    endtask

    task automatic test_sub_patterns();
        apply(32'h0000_0010, 32'h0000_0001, 1'b0, 1'b1, 2'b00);
        apply(32'h0000_0000, 32'h0000_0001, 1'b0, 1'b1, 2'b00);
        apply(32'h0000_0080, 32'h0000_0001, 1'b0, 1'b1, 2'b00);
        apply(32'h0000_0005, 32'h0000_0005, 1'b1, 1'b1, 2'b01);
        apply(32'h0000_0005, 32'h0000_0004, 1'b1, 1'b1, 2'b01);
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 2'b10);
        apply(32'hDEAD_BEEF, 32'h1234_5678, 1'b1, 1'b1, 2'b10);
    endtask

    task automatic test_width_isolation();
        // R1: upper operand bits must not leak into an 8- or 16-bit result
        apply(32'hABCD_EF01, 32'h1234_56FF, 1'b0, 1'b0, 2'b00);
        apply(32'hFFFF_0000, 32'hFFFF_0000, 1'b0, 1'b0, 2'b01);
        apply(32'h5555_0003, 32'hAAAA_0004, 1'b0, 1'b1, 2'b01);
        // R9: size code 11 behaves as 32 bits
        apply(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 2'b11);
        apply(32'h0001_0000, 32'h0000_0001, 1'b0, 1'b1, 2'b11);
    endtask

    task automatic test_parity_low_byte();
        // R8: upper result bits do not count towards parity
        apply(32'h0100_0003, 32'h0000_0000, 1'b0, 1'b0, 2'b10);
        apply(32'h0001_0001, 32'h0000_0000, 1'b0, 1'b0, 2'b01);
        apply(32'h0000_0007, 32'h0000_0000, 1'b0, 1'b0, 2'b00);
    endtask

    task automatic test_sweep();
        for (int i = 0; i < 64; i++) begin
            apply(32'(i * 37 + 5) ^ 32'h9E37_79B9 * 32'(i), 32'(i * 113) ^ 32'h0F0F_3C3C,
                  1'(i >> 1), 1'(i), 2'(i >> 2));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        @(negedge clk);
        rst_n = 1'b1;
        test_add_patterns();
        test_sub_patterns();
        test_width_isolation();
        test_parity_low_byte();
        test_sweep();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule